// File: doc/BRIEF.md
# Operand Bypass and Load-Interlock Controller

This unit decides, for an in-order five-stage integer pipeline (fetch, decode, execute, memory, writeback), where each ALU operand in the execute stage should come from. It also decides when the front of the pipe must pause for a load. It is purely combinational. It looks at the register numbers carried in the pipeline registers and produces two 2-bit operand-source codes. It also produces three stall controls. The datapath multiplexers, the register file and branch logic live elsewhere.

Each operand can take its value from one of three places: the register file, the result leaving the memory stage, or the result sitting in the execute/memory register. When a result from both later stages targets the same source, the younger one (execute/memory) is chosen. A load whose destination is needed by the very next instruction cannot be bypassed in time. The unit therefore freezes the program counter and the fetch/decode register for one cycle and injects an empty slot into the decode/execute register. On the repeated decode, the loaded value reaches the operand through the memory/writeback path. The register file is assumed to return a value that is written and read in the same cycle, so no bypass into decode is produced.

Top module: `hz_ctrl`

## Requirements
- R1: An operand source code of 2'b10 (execute/memory result) is produced when the execute/memory stage writes a register, its destination is nonzero, and that destination equals the operand's source (operand A uses the execute-stage rs field, operand B the execute-stage rt field).
- R2: A code of 2'b01 (memory/writeback result) is produced when the memory/writeback stage writes a register, its destination is nonzero and equals the operand's source, and the condition of R1 does not hold for that operand.
- R3: A code of 2'b00 (register file value) is produced in every other case; the code 2'b11 never appears.
- R4: When both later stages match the same nonzero source, the code is 2'b10 (youngest result wins).
- R5: A destination of register 0 never causes a bypass, whatever the write flags.
- R6: A stage whose register-write flag is low never causes a bypass, even when its destination matches.
- R7: When the decode/execute instruction reads memory and its rt field equals the fetch/decode rs or rt field, `pc_hold_o`, `fd_hold_o` and `dx_bubble_o` are all 1. This holds for register 0 as well, because the interlock does not compare against zero.
- R8: `pc_hold_o`, `fd_hold_o` and `dx_bubble_o` are always equal. They are 0 whenever the decode/execute instruction does not read memory or neither fetch/decode source matches its rt field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dx_rs_i | input | AW | rs source field held in the decode/execute register |
| dx_rt_i | input | AW | rt source field of decode/execute (also the load destination) |
| dx_mem_rd_i | input | 1 | decode/execute instruction reads memory (load) |
| fd_rs_i | input | AW | rs field of the instruction in the fetch/decode register |
| fd_rt_i | input | AW | rt field of the instruction in the fetch/decode register |
| xm_wr_en_i | input | 1 | execute/memory instruction writes a register |
| xm_dst_i | input | AW | execute/memory destination register |
| mw_wr_en_i | input | 1 | memory/writeback instruction writes a register |
| mw_dst_i | input | AW | memory/writeback destination register |
| fwd_a_o | output | 2 | operand A source code (00 file, 01 mem/wb, 10 exe/mem) |
| fwd_b_o | output | 2 | operand B source code (00 file, 01 mem/wb, 10 exe/mem) |
| pc_hold_o | output | 1 | keep the program counter unchanged this cycle |
| fd_hold_o | output | 1 | keep the fetch/decode register unchanged this cycle |
| dx_bubble_o | output | 1 | zero the control fields entering decode/execute |

## Verification
The hardest situation to reach is a double match, where both later stages write the same nonzero register that an operand reads. Only one combination in several hundred produces it, and a directed test easily misses it on one operand. The bench is built with 2-bit register numbers, so the whole forwarding input space of 1024 combinations and the whole interlock space of 128 combinations are swept. Every double match and every register-0 case therefore occurs on both operands, and the expected codes are computed from R1 to R8.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    SRC_FILE  = 2'b00,
    SRC_MEMWB = 2'b01,
    SRC_EXMEM = 2'b10
  } src_sel_e;
  localparam int NUM_OPERANDS = 2;
endpackage

// File: rtl/hz_src_pick.sv
module hz_src_pick
  import hz_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic [AW-1:0] src_i,
  input  logic          xm_wr_en_i,
  input  logic [AW-1:0] xm_dst_i,
  input  logic          mw_wr_en_i,
  input  logic [AW-1:0] mw_dst_i,
  output src_sel_e      sel_o
);
  localparam logic [AW-1:0] ZERO_REG = '0;

  logic xm_hit;
  logic mw_hit;

  assign xm_hit = xm_wr_en_i && (xm_dst_i != ZERO_REG) && (xm_dst_i == src_i);
  assign mw_hit = mw_wr_en_i && (mw_dst_i != ZERO_REG) && (mw_dst_i == src_i);

  // Younger producer is checked first.
  always_comb begin
    if (xm_hit)      sel_o = SRC_EXMEM;
    else if (mw_hit) sel_o = SRC_MEMWB;
    else             sel_o = SRC_FILE;
  end

  always_comb begin
    // R6: a stage that does not write never drives a bypass
    assert_nowr_R6: assert (xm_wr_en_i || mw_wr_en_i || sel_o == SRC_FILE);
  end
endmodule

// File: rtl/hz_load_lock.sv
module hz_load_lock #(
  parameter int AW = 5
) (
  input  logic          dx_mem_rd_i,
  input  logic [AW-1:0] dx_rt_i,
  input  logic [AW-1:0] fd_rs_i,
  input  logic [AW-1:0] fd_rt_i,
  output logic          stall_o
);
  logic rs_dep;
  logic rt_dep;

  assign rs_dep  = (dx_rt_i == fd_rs_i);
  assign rt_dep  = (dx_rt_i == fd_rt_i);
  assign stall_o = dx_mem_rd_i && (rs_dep || rt_dep);

  always_comb begin
    // R8: no load in decode/execute means no interlock
    assert_noload_R8: assert (dx_mem_rd_i || !stall_o);
  end
endmodule

// File: rtl/hz_ctrl.sv
module hz_ctrl
  import hz_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic [AW-1:0] dx_rs_i,
  input  logic [AW-1:0] dx_rt_i,
  input  logic          dx_mem_rd_i,
  input  logic [AW-1:0] fd_rs_i,
  input  logic [AW-1:0] fd_rt_i,
  input  logic          xm_wr_en_i,
  input  logic [AW-1:0] xm_dst_i,
  input  logic          mw_wr_en_i,
  input  logic [AW-1:0] mw_dst_i,
  output logic [1:0]    fwd_a_o,
  output logic [1:0]    fwd_b_o,
  output logic          pc_hold_o,
  output logic          fd_hold_o,
  output logic          dx_bubble_o
);
  logic [AW-1:0] op_src [NUM_OPERANDS];
  src_sel_e      op_sel [NUM_OPERANDS];
  logic          stall;

  assign op_src[0] = dx_rs_i;
  assign op_src[1] = dx_rt_i;

  for (genvar g = 0; g < NUM_OPERANDS; g++) begin : g_op
    hz_src_pick #(.AW(AW)) u_pick (
      .src_i      (op_src[g]),
      .xm_wr_en_i (xm_wr_en_i),
      .xm_dst_i   (xm_dst_i),
      .mw_wr_en_i (mw_wr_en_i),
      .mw_dst_i   (mw_dst_i),
      .sel_o      (op_sel[g])
    );
  end

  hz_load_lock #(.AW(AW)) u_lock (
    .dx_mem_rd_i (dx_mem_rd_i),
    .dx_rt_i     (dx_rt_i),
    .fd_rs_i     (fd_rs_i),
    .fd_rt_i     (fd_rt_i),
    .stall_o     (stall)
  );

  assign fwd_a_o     = op_sel[0];
  assign fwd_b_o     = op_sel[1];
  assign pc_hold_o   = stall;
  assign fd_hold_o   = stall;
  assign dx_bubble_o = stall;

  always_comb begin
    // R3: the unused code never leaves the unit
    assert_legal_R3: assert (fwd_a_o != 2'b11 && fwd_b_o != 2'b11);
    // R5: with both destinations at register 0 no bypass is chosen
    assert_zero_R5: assert (xm_dst_i != '0 || mw_dst_i != '0 ||
                            (fwd_a_o == 2'b00 && fwd_b_o == 2'b00));
    // R4: a matching younger writer always wins on operand A
    assert_prio_R4: assert (!(xm_wr_en_i && xm_dst_i != '0 && xm_dst_i == dx_rs_i) ||
                            fwd_a_o == 2'b10);
    // R7: a load feeding the next rs forces a stall
    assert_lock_R7: assert (!(dx_mem_rd_i && dx_rt_i == fd_rs_i) || dx_bubble_o);
  end
endmodule

// File: tb/hz_ctrl_tb.sv
module hz_ctrl_tb;
  localparam int AW = 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [AW-1:0] dx_rs, dx_rt, fd_rs, fd_rt, xm_dst, mw_dst;
  logic dx_mem_rd, xm_wr, mw_wr;
  logic [1:0] fwd_a, fwd_b;
  logic pc_hold, fd_hold, bubble;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  hz_ctrl #(.AW(AW)) u_dut (
    .dx_rs_i(dx_rs), .dx_rt_i(dx_rt), .dx_mem_rd_i(dx_mem_rd),
    .fd_rs_i(fd_rs), .fd_rt_i(fd_rt),
    .xm_wr_en_i(xm_wr), .xm_dst_i(xm_dst),
    .mw_wr_en_i(mw_wr), .mw_dst_i(mw_dst),
    .fwd_a_o(fwd_a), .fwd_b_o(fwd_b),
    .pc_hold_o(pc_hold), .fd_hold_o(fd_hold), .dx_bubble_o(bubble)
  );

  function automatic logic [1:0] exp_sel(input logic [AW-1:0] src);
    if (xm_wr && xm_dst != 0 && xm_dst == src) return 2'b10;
    if (mw_wr && mw_dst != 0 && mw_dst == src) return 2'b01;
    return 2'b00;
  endfunction

  function automatic string sel_tag(input logic [AW-1:0] src);
    bit xm_m = (xm_dst == src) && src != 0;
    bit mw_m = (mw_dst == src) && src != 0;
    if (xm_wr && mw_wr && xm_m && mw_m) return "R4";
    if (xm_wr && xm_m) return "R1";
    if (mw_wr && mw_m) return "R2";
    if (src == 0 && (xm_dst == 0 || mw_dst == 0)) return "R5";
    if (xm_m || mw_m) return "R6";
    return "R3";
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  initial begin
    {dx_rs, dx_rt, fd_rs, fd_rt, xm_dst, mw_dst} = '0;
    {dx_mem_rd, xm_wr, mw_wr} = '0;
    @(negedge clk);
    // idle inputs: register file sources, no stall
    check("R3", "idle fwd_a", fwd_a, 2'b00);
    check("R3", "idle fwd_b", fwd_b, 2'b00);
    check("R8", "idle stall", {1'b0, bubble}, 2'b00);

    // Full forwarding sweep: R1 R2 R3 R4 R5 R6
    for (int i = 0; i < 1024; i++) begin
      @(posedge clk);
      dx_rs  = i[1:0];
      dx_rt  = i[3:2];
      xm_wr  = i[4];
      xm_dst = i[6:5];
      mw_wr  = i[7];
      mw_dst = i[9:8];
      dx_mem_rd = 1'b0;
      fd_rs = 2'd1;
      fd_rt = 2'd2;
      @(negedge clk);
      check(sel_tag(dx_rs), "fwd_a", fwd_a, exp_sel(dx_rs));
      check(sel_tag(dx_rt), "fwd_b", fwd_b, exp_sel(dx_rt));
    end

    // Full interlock sweep: R7 R8
    for (int j = 0; j < 128; j++) begin
      @(posedge clk);
      xm_wr = 1'b0;
      mw_wr = 1'b0;
      dx_rs = 2'd0;
      dx_mem_rd = j[0];
      dx_rt = j[2:1];
      fd_rs = j[4:3];
      fd_rt = j[6:5];
      @(negedge clk);
      begin
        logic s;
        s = dx_mem_rd && (dx_rt == fd_rs || dx_rt == fd_rt);
        check(s ? "R7" : "R8", "pc_hold", {1'b0, pc_hold}, {1'b0, s});
        check(s ? "R7" : "R8", "fd_hold", {1'b0, fd_hold}, {1'b0, s});
        check(s ? "R7" : "R8", "dx_bubble", {1'b0, bubble}, {1'b0, s});
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R8 actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule